// File: doc/BRIEF.md
# Single-Error-Correcting Internal Data Memory

This block is a small byte-wide data memory whose contents survive single-bit upsets. Each byte is expanded into a 13-bit codeword on the way in: four Hamming check bits and one overall parity bit are added. Only the codeword is kept in storage. On every read the selected codeword goes through a syndrome decoder. A single flipped bit is repaired in the returned byte, and two flipped bits are reported as uncorrectable.

Encoding and decoding are purely combinational, so the block keeps the access timing of a plain register-file RAM. A write is committed on the rising clock edge. Read data follows the address combinationally, in the same cycle. The stored copy is never rewritten by a read. A repaired upset therefore stays in storage until that location is written again.

A verification-only injection port XORs a mask into the stored codeword at any address. This lets a testbench model upsets in any of the 13 stored bits. All interfaces are plain level signals. There is no handshake, because every access completes within its own cycle.

Top module: `secded_ram`

## Requirements
- R1: After reset every location reads as 0x00, with both `corrected` and `double_err` low.
- R2: A byte written with `wr_en` at a rising edge is returned on `rd_data` from the following cycle when `addr` selects it, with both flags low.
- R3: Codeword layout. Mask bit 0 is the overall parity bit, which gives even parity over all 13 bits. Mask bits 1, 2, 4 and 8 hold the Hamming check bits. Data bits 0 to 7 sit in mask bits 3, 5, 6, 7, 9, 10, 11 and 12, in that order.
- R4: When exactly one of the 13 stored bits is flipped, `rd_data` returns the originally written byte and `corrected` is high, with `double_err` low.
- R5: When exactly two stored bits are flipped, `double_err` is high and `corrected` is low. `rd_data` then carries the stored data bits uncorrected.
- R6: A read that corrects data leaves storage unchanged. Repeated reads of that location keep reporting `corrected`, until a new write to it clears the upset.
- R7: An injection changes only the codeword at `inj_addr`. Other locations read back unchanged.
- R8: If a write and an injection target the same address in the same cycle, the write wins and the location holds a clean codeword of the new byte.
- R9: `rd_data` and both flags follow a change of `addr` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears all codewords |
| wr_en | input | 1 | Write the byte on `wr_data` to `addr` at the next rising edge |
| addr | input | 7 | Shared read/write address |
| wr_data | input | 8 | Byte to be encoded and stored |
| rd_data | output | 8 | Corrected byte at `addr` |
| corrected | output | 1 | The codeword read at `addr` held one flipped bit |
| double_err | output | 1 | The codeword read at `addr` holds an uncorrectable error |
| inj_en | input | 1 | Apply `inj_mask` at the next rising edge |
| inj_addr | input | 7 | Location to corrupt |
| inj_mask | input | 13 | Bits of the stored codeword to flip |

## Verification
The bench flips each of the 13 codeword positions in turn, including the overall parity bit. A decoder that mishandles a zero syndrome with odd parity would either drop the flag or corrupt a data bit. Double flips are aimed at two data positions, so the layout of R3 becomes visible in the uncorrected byte. A swapped bit order or a decoder that still attempts a correction would return the wrong byte. Repeated reads after a correction would expose a hidden write-back. A write that collides with an injection would expose a wrong priority. Neighbouring addresses are read after injections, to catch a decoder that corrupts the wrong row.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // Number of Hamming check bits needed for a data width.
  function automatic int check_bits(input int data_w);
    int p;
    p = 1;
    while ((1 << p) < data_w + p + 1) p++;
    return p;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int P_W   = check_bits(DATA_W),
  localparam int N     = DATA_W + P_W,
  localparam int CW_W  = N + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);

  always_comb begin
    logic [CW_W-1:0] cw;
    int d;
    cw = '0;
    d  = 0;
    // scatter data into non power-of-two positions
    for (int pos = 1; pos <= N; pos++) begin
      if (!is_pow2(pos)) begin
        cw[pos] = data_i[d];
        d++;
      end
    end
    // each check bit covers positions whose index has its bit set
    for (int pos = 1; pos <= N; pos++) begin
      if (!is_pow2(pos)) begin
        for (int k = 0; k < P_W; k++) begin
          if (((pos >> k) & 1) == 1) cw[1 << k] = cw[1 << k] ^ cw[pos];
        end
      end
    end
    cw[0] = ^cw[N:1];
    cw_o  = cw;
  end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int P_W   = check_bits(DATA_W),
  localparam int N     = DATA_W + P_W,
  localparam int CW_W  = N + 1
) (
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic              corr_o,
  output logic              dbl_o
);

  logic [P_W-1:0]  syn;
  logic            par_odd;
  logic [CW_W-1:0] fixed;

  always_comb begin
    syn = '0;
    for (int pos = 1; pos <= N; pos++) begin
      if (cw_i[pos]) syn = syn ^ P_W'(pos);
    end
  end

  assign par_odd = ^cw_i;

  always_comb begin
    fixed  = cw_i;
    corr_o = 1'b0;
    dbl_o  = 1'b0;
    if (syn == '0) begin
      // only the overall parity bit can be wrong; data is intact
      corr_o = par_odd;
    end else if (par_odd) begin
      if (int'(syn) <= N) begin
        fixed[syn] = ~cw_i[syn];
        corr_o     = 1'b1;
      end else begin
        dbl_o = 1'b1;
      end
    end else begin
      dbl_o = 1'b1;
    end
  end

  always_comb begin
    int d;
    d      = 0;
    data_o = '0;
    for (int pos = 1; pos <= N; pos++) begin
      if (!is_pow2(pos)) begin
        data_o[d] = fixed[pos];
        d++;
      end
    end
  end

endmodule

// File: rtl/secded_store.sv
module secded_store #(
  parameter int ADDR_W = 7,
  parameter int CW_W   = 13,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW_W-1:0]   wr_cw,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [CW_W-1:0]   inj_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CW_W-1:0]   rd_cw
);

  logic [CW_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (inj_en) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
      // a write in the same cycle overrides the injection
      if (wr_en) mem[wr_addr] <= wr_cw;
    end
  end

  assign rd_cw = mem[rd_addr];

endmodule

// File: rtl/secded_ram.sv
module secded_ram
  import secded_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int P_W   = check_bits(DATA_W),
  localparam int CW_W  = DATA_W + P_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              corrected,
  output logic              double_err,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [CW_W-1:0]   inj_mask
);

  logic [CW_W-1:0] enc_cw;
  logic [CW_W-1:0] rd_cw;

  secded_enc #(.DATA_W(DATA_W)) enc_i (
    .data_i (wr_data),
    .cw_o   (enc_cw)
  );

  secded_store #(.ADDR_W(ADDR_W), .CW_W(CW_W)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (addr),
    .wr_cw    (enc_cw),
    .inj_en   (inj_en),
    .inj_addr (inj_addr),
    .inj_mask (inj_mask),
    .rd_addr  (addr),
    .rd_cw    (rd_cw)
  );

  secded_dec #(.DATA_W(DATA_W)) dec_i (
    .cw_i   (rd_cw),
    .data_o (rd_data),
    .corr_o (corrected),
    .dbl_o  (double_err)
  );

endmodule

// File: rtl/secded_ram_chk.sv
module secded_ram_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              corrected,
  input logic              double_err,
  input logic              inj_en,
  input logic [ADDR_W-1:0] inj_addr
);

  // R4 R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(corrected && double_err));

  // R2
  write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && !$past(inj_en) && addr == $past(addr))
      |-> (rd_data == $past(wr_data) && !corrected && !double_err));

  // R7
  inject_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(inj_en) && !$past(wr_en) &&
     $past(inj_addr) != addr && $stable(addr))
      |-> ($stable(rd_data) && $stable(corrected) && $stable(double_err)));

  // R6
  no_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(corrected) && !$past(wr_en) && !$past(inj_en) && $stable(addr))
      |-> (corrected && $stable(rd_data)));

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(inj_en) && $past(inj_addr) == $past(addr) &&
     $stable(addr))
      |-> (rd_data == $past(wr_data) && !corrected && !double_err));

endmodule

bind secded_ram secded_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .corrected  (corrected),
  .double_err (double_err),
  .inj_en     (inj_en),
  .inj_addr   (inj_addr)
);

// File: tb/secded_ram_tb.sv
module secded_ram_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [6:0] a;
    logic [7:0] d;
    logic       c;
    logic       e;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        corrected, double_err;
  logic        inj_en = 1'b0;
  logic [6:0]  inj_addr = '0;
  logic [12:0] inj_mask = '0;

  int checks = 0;
  int fails = 0;
  exp_t q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  secded_ram dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .corrected(corrected), .double_err(double_err),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask)
  );

  // R3: codeword position of data bit k
  function automatic int dpos(input int k);
    int map [8] = '{3, 5, 6, 7, 9, 10, 11, 12};
    return map[k];
  endfunction

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic inj(input logic [6:0] a, input logic [12:0] m);
    @(negedge clk);
    inj_addr = a; inj_mask = m; inj_en = 1'b1;
    @(negedge clk);
    inj_en = 1'b0; inj_mask = '0;
  endtask

  // driver: set address, push expectation, let the monitor compare
  task automatic rd(input logic [6:0] a, input logic [7:0] d,
                    input logic c, input logic e, input string tag);
    exp_t x;
    addr = a;
    x.a = a; x.d = d; x.c = c; x.e = e; x.tag = tag;
    q.push_back(x);
    #2;
  endtask

  // monitor
  initial begin
    forever begin
      exp_t x;
      wait (q.size() > 0);
      #1;
      x = q.pop_front();
      checks++;
      if (rd_data !== x.d || corrected !== x.c || double_err !== x.e) begin
        fails++;
        $display("FAIL %s addr=%0d actual data=%02h c=%b e=%b expected data=%02h c=%b e=%b",
                 x.tag, x.a, rd_data, corrected, double_err, x.d, x.c, x.e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    rd(7'd0,   8'h00, 0, 0, "R1 reset");
    rd(7'd127, 8'h00, 0, 0, "R1 reset");

    wr(7'd5, 8'h3C);
    wr(7'd6, 8'hC3);
    rd(7'd5, 8'h3C, 0, 0, "R2 readback");
    // R9: address change without any clock edge
    rd(7'd6, 8'hC3, 0, 0, "R9 same-cycle read");
    rd(7'd5, 8'h3C, 0, 0, "R9 same-cycle read");

    // R4: every single codeword position, parity bit included
    for (int b = 0; b < 13; b++) begin
      wr(7'd20, 8'hA5);
      inj(7'd20, 13'(1) << b);
      rd(7'd20, 8'hA5, 1, 0, "R4 single flip");
    end
    wr(7'd21, 8'h00);
    inj(7'd21, 13'(1) << dpos(7));
    rd(7'd21, 8'h00, 1, 0, "R4 single flip on zero");

    // R5/R3: two data bits flipped show through uncorrected
    wr(7'd30, 8'h5A);
    inj(7'd30, (13'(1) << dpos(0)) | (13'(1) << dpos(1)));
    rd(7'd30, 8'h59, 0, 1, "R5 R3 double data flip");
    wr(7'd31, 8'h0F);
    inj(7'd31, (13'(1) << dpos(7)) | (13'(1) << dpos(4)));
    rd(7'd31, 8'h9F, 0, 1, "R5 R3 double data flip high");
    wr(7'd32, 8'h77);
    inj(7'd32, 13'b0_0000_0000_0110);
    rd(7'd32, 8'h77, 0, 1, "R5 R3 double check flip");
    wr(7'd33, 8'hE1);
    inj(7'd33, (13'(1) << 12) | 13'(2));
    rd(7'd33, 8'h61, 0, 1, "R5 double flip syndrome out of range");

    // R6: stored upset persists until rewritten
    wr(7'd40, 8'h96);
    inj(7'd40, 13'(1) << dpos(3));
    rd(7'd40, 8'h96, 1, 0, "R6 first corrected read");
    repeat (3) @(negedge clk);
    rd(7'd40, 8'h96, 1, 0, "R6 upset still stored");
    inj(7'd40, 13'(1) << dpos(5));
    rd(7'd40, 8'hBE, 0, 1, "R6 second flip accumulates");
    wr(7'd40, 8'h11);
    rd(7'd40, 8'h11, 0, 0, "R6 rewrite clears");

    // R7: neighbours untouched
    wr(7'd50, 8'h44);
    wr(7'd51, 8'h55);
    wr(7'd52, 8'h66);
    inj(7'd51, (13'(1) << 3) | (13'(1) << 5));
    rd(7'd50, 8'h44, 0, 0, "R7 neighbour below");
    rd(7'd52, 8'h66, 0, 0, "R7 neighbour above");
    rd(7'd51, 8'h56, 0, 1, "R7 target hit");

    // R8: simultaneous write and inject to same address
    @(negedge clk);
    addr = 7'd60; wr_data = 8'hD2; wr_en = 1'b1;
    inj_addr = 7'd60; inj_mask = 13'(1) << dpos(2); inj_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; inj_en = 1'b0; inj_mask = '0;
    rd(7'd60, 8'hD2, 0, 0, "R8 write wins");

    wait (q.size() == 0);
    #5;
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule